// File: doc/BRIEF.md
# Video Reserved-Code Remapper

This block is a single pipeline stage on a 10-bit video sample stream. It keeps the picture content out of the reserved code bands at the top and bottom of the code space. It also restores the full 10-bit form of timing-reference and ancillary-data preamble words that arrive with only their upper 8 bits significant. Which samples belong to the active picture, and which positions hold preamble words, is decided upstream. Both facts arrive as per-sample flags alongside the data.

Each accepted sample is rewritten according to its context and leaves the block one clock later. The valid strobe and the two context flags are delayed to stay aligned with the data. When the bypass control is high, every sample is forwarded unchanged. When it is low, remapping is in force. Blanking samples that are not preamble words are never altered.

Top module: `video_code_remap`

## Requirements
- R1: While `rst` is high, at the clock edge `out_vld`, `out_data`, `out_act` and `out_pre` are all forced to 0.
- R2: A sample accepted with `in_vld` high appears on the outputs exactly one clock later, with `out_vld` high. `out_act` and `out_pre` carry the same sample's `in_act` and `in_pre`.
- R3: With `fix_bypass` low, `in_act` high and `in_pre` low, a code from 3FCh to 3FFh is output as 3FBh.
- R4: With `fix_bypass` low, `in_act` high and `in_pre` low, a code from 000h to 003h is output as 004h.
- R5: With `fix_bypass` low and `in_pre` high, a code from 3FCh to 3FFh is output as 3FFh. This holds whatever the value of `in_act`, because the preamble flag takes priority.
- R6: With `fix_bypass` low and `in_pre` high, a code from 000h to 003h is output as 000h. This holds whatever the value of `in_act`.
- R7: With `in_act` and `in_pre` both low, every code from 000h to 3FFh is output unchanged.
- R8: With `fix_bypass` low, a code from 004h to 3FBh is output unchanged in active-picture and preamble positions.
- R9: With `fix_bypass` high, every code is output unchanged in every context.
- R10: A cycle with `in_vld` low produces `out_vld` low one clock later, and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fix_bypass | input | 1 | High: forward samples unchanged; low: remap |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 10 | Input sample code |
| in_act | input | 1 | Sample lies inside the active picture |
| in_pre | input | 1 | Sample is a TRS or ancillary preamble word |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 10 | Corrected sample code |
| out_act | output | 1 | Delayed active-picture flag |
| out_pre | output | 1 | Delayed preamble flag |

## Verification
The bench builds the block with its default parameters: a 10-bit sample and a reserved band four codes wide at each end. At this size the entire code space is only 1024 values. The bench therefore sweeps every code through each of the four flag combinations, with the bypass control in both states. That covers every band edge, such as 003h/004h and 3FBh/3FCh, and the priority of the preamble flag over the active-picture flag. Idle cycles are mixed into the stream so that the one-clock alignment and the hold of the data output are exercised between samples.

// File: rtl/vr_pkg.sv
package vr_pkg;
  // Where a code sits relative to the reserved bands
  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } band_e;

  // Which rewrite rule applies to a sample
  typedef enum logic [1:0] {
    CTX_PASS     = 2'd0,
    CTX_PICTURE  = 2'd1,
    CTX_PREAMBLE = 2'd2
  } ctx_e;
endpackage

// File: rtl/vr_band.sv
module vr_band #(
  parameter int DW  = 10,
  parameter int RSV = 4
) (
  input  logic [DW-1:0] code,
  output vr_pkg::band_e band
);
  localparam int MAXV = (1 << DW) - 1;
  localparam logic [DW-1:0] HI_LEG = DW'(MAXV - RSV);
  localparam logic [DW-1:0] LO_LEG = DW'(RSV);

  always_comb begin
    if (code > HI_LEG)      band = vr_pkg::BAND_HIGH;
    else if (code < LO_LEG) band = vr_pkg::BAND_LOW;
    else                    band = vr_pkg::BAND_MID;
  end
endmodule

// File: rtl/vr_rewrite.sv
module vr_rewrite #(
  parameter int DW  = 10,
  parameter int RSV = 4
) (
  input  logic [DW-1:0] code,
  input  vr_pkg::band_e band,
  input  vr_pkg::ctx_e  ctx,
  output logic [DW-1:0] result
);
  localparam int MAXV = (1 << DW) - 1;
  localparam logic [DW-1:0] HI_LEG = DW'(MAXV - RSV);
  localparam logic [DW-1:0] LO_LEG = DW'(RSV);
  localparam logic [DW-1:0] ALL1   = DW'(MAXV);
  localparam logic [DW-1:0] ALL0   = '0;

  always_comb begin
    result = code;
    unique case (ctx)
      vr_pkg::CTX_PICTURE: begin
        if (band == vr_pkg::BAND_HIGH)     result = HI_LEG;
        else if (band == vr_pkg::BAND_LOW) result = LO_LEG;
      end
      vr_pkg::CTX_PREAMBLE: begin
        if (band == vr_pkg::BAND_HIGH)     result = ALL1;
        else if (band == vr_pkg::BAND_LOW) result = ALL0;
      end
      default: result = code;
    endcase
  end
endmodule

// File: rtl/video_code_remap.sv
module video_code_remap #(
  parameter int DW  = 10,
  parameter int RSV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fix_bypass,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          in_act,
  input  logic          in_pre,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic          out_act,
  output logic          out_pre
);
  localparam int MAXV = (1 << DW) - 1;
  localparam logic [DW-1:0] HI_LEG = DW'(MAXV - RSV);
  localparam logic [DW-1:0] LO_LEG = DW'(RSV);

  vr_pkg::band_e band;
  vr_pkg::ctx_e  ctx;
  logic [DW-1:0] fixed;

  // Preamble flag outranks the active-picture flag
  always_comb begin
    if (fix_bypass)  ctx = vr_pkg::CTX_PASS;
    else if (in_pre) ctx = vr_pkg::CTX_PREAMBLE;
    else if (in_act) ctx = vr_pkg::CTX_PICTURE;
    else             ctx = vr_pkg::CTX_PASS;
  end

  vr_band #(.DW(DW), .RSV(RSV)) u_band (
    .code (in_data),
    .band (band)
  );

  vr_rewrite #(.DW(DW), .RSV(RSV)) u_rewrite (
    .code   (in_data),
    .band   (band),
    .ctx    (ctx),
    .result (fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_act  <= 1'b0;
      out_pre  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_data <= fixed;
        out_act  <= in_act;
        out_pre  <= in_pre;
      end
    end
  end

  // R2: strobe follows the input strobe by one clock
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  // R10: an idle input cycle gives an idle output cycle and holds the data
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(out_data)));
  // R3 / R4: active picture output stays within the legal band
  a_r3_picture_bounded: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_act && !in_pre && !fix_bypass) |=>
      (out_data <= HI_LEG && out_data >= LO_LEG));
  // R5 / R6: preamble output never lands inside a reserved band except at its extreme
  a_r5_preamble_extremes: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_pre && !fix_bypass) |=>
      ((out_data >= LO_LEG && out_data <= HI_LEG) ||
       out_data == '0 || out_data == DW'(MAXV)));
  // R9: bypass forwards the sample untouched
  a_r9_bypass_clean: assert property (@(posedge clk) disable iff (rst)
    (in_vld && fix_bypass) |=> (out_data == $past(in_data)));
endmodule

// File: tb/sim_video_code_remap.sv
module sim_video_code_remap;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fix_bypass = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_act = 1'b0;
  logic          in_pre = 1'b0;
  logic          out_vld;
  logic [DW-1:0] out_data;
  logic          out_act;
  logic          out_pre;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected item: {act, pre, data} and the requirement it exercises
  logic [DW+1:0] q_exp[$];
  int            q_req[$];
  logic [DW-1:0] last_data = '0;

  always #2.5 clk = ~clk;

  video_code_remap #(.DW(DW), .RSV(4)) u0 (
    .clk(clk), .rst(rst), .fix_bypass(fix_bypass),
    .in_vld(in_vld), .in_data(in_data), .in_act(in_act), .in_pre(in_pre),
    .out_vld(out_vld), .out_data(out_data), .out_act(out_act), .out_pre(out_pre)
  );

  task automatic check(bit ok, int req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic drive(int code, bit act, bit pre, bit byp);
    logic [DW-1:0] e;
    int req;
    e = DW'(code);
    if (byp) req = 9;                    // R9
    else if (pre) begin
      if (code >= 'h3FC) begin e = 'h3FF; req = 5; end      // R5
      else if (code <= 3) begin e = 'h000; req = 6; end     // R6
      else req = 8;                                        // R8
    end else if (act) begin
      if (code >= 'h3FC) begin e = 'h3FB; req = 3; end      // R3
      else if (code <= 3) begin e = 'h004; req = 4; end     // R4
      else req = 8;                                        // R8
    end else req = 7;                    // R7
    @(negedge clk);
    fix_bypass = byp; in_vld = 1'b1; in_data = DW'(code);
    in_act = act; in_pre = pre;
    q_exp.push_back({act, pre, e});
    q_req.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0; in_data = ~in_data; in_act = ~in_act;
  endtask

  // Monitor: scoreboard compare just after each active edge
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (out_vld) begin
        if (q_exp.size() == 0) check(1'b0, 2, 1, 0);   // R2: unexpected output
        else begin
          logic [DW+1:0] e;
          int r;
          e = q_exp.pop_front();
          r = q_req.pop_front();
          check(out_data == e[DW-1:0], r, out_data, e[DW-1:0]);
          check({out_act, out_pre} == e[DW+1:DW], 2, {out_act, out_pre}, e[DW+1:DW]); // R2 flags
          last_data = out_data;
        end
      end else begin
        check(out_data == last_data, 10, out_data, last_data); // R10 hold
      end
    end
  end

  initial begin
    int n = 0;
    in_vld = 1'b1; in_data = 'h155; in_act = 1'b1; in_pre = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(out_vld == 0 && out_data == 0 && out_act == 0 && out_pre == 0,
          1, {out_vld, out_act, out_pre, out_data}, 0);
    @(negedge clk);
    in_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    // R2: one-clock latency, probed directly
    drive('h200, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #1;
    check(out_vld == 1'b1, 2, out_vld, 1);
    for (int byp = 0; byp < 2; byp++) begin
      for (int ctx = 0; ctx < 4; ctx++) begin
        for (int c = 0; c < 1024; c++) begin
          drive(c, ctx[0], ctx[1], byp[0]);
          n++;
          if (n % 7 == 0) idle();
        end
      end
    end
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(q_exp.size() == 0, 2, q_exp.size(), 0);  // R2: every sample delivered
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule